// File: doc/BRIEF.md
# Vector Table Lookup Permute

This block builds a new vector by gathering elements from a data vector. Every lane of an index vector gives the position of the data element that its lane of the result receives. The element width is picked for each operation from 8, 16, 32 or 64 bits. The number of lanes is therefore the vector length divided by that width, so it changes with each operation.

Any index that points past the last element makes its lane read as zero. This covers indices equal to the element count. The bound moves with the element size, so the same index bits can be in range at one size and out of range at another.

The vector length is fixed at build time as a multiple of 128 bits, at most 2048. An operation is offered with a one-cycle valid strobe. The gathered vector is registered and comes out on the next clock with its own valid flag.

Top module: `vtbl_permute`

## Requirements
- R1: The 2-bit size code selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane 0 occupies the least significant bits of every vector, and lane i occupies bits [i*W +: W] for width W.
- R2: The index for result lane i is lane i of the index vector, read as an unsigned number of the same width W, with all W bits significant.
- R3: When that index is below the element count, result lane i equals the data element at that index. The gather is taken from the data vector as presented, so one source element may feed any number of lanes.
- R4: When that index is equal to or above the element count, result lane i is zero.
- R5: out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise.
- R6: While in_valid is low, out_vec keeps the last gathered result.
- R7: While rst is high at a clock edge, out_valid and out_vec are cleared to zero on that edge.
- R8: The element count equals VLEN/8 divided by the element size in bytes. With VLEN = 256 this gives 32, 16, 8 and 4 lanes for size codes 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe; the inputs are sampled when it is high |
| in_size | input | 2 | Element size code (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| in_data | input | VLEN | Data vector that elements are gathered from |
| in_index | input | VLEN | Index vector, one unsigned index per lane |
| out_valid | output | 1 | High in the cycle after an accepted operation |
| out_vec | output | VLEN | Registered gathered result |

## Verification
The bench builds the block at VLEN = 256, so the element bound is 32, 16, 8 or 4 depending on the size code. It drives all four size codes with indices that are ascending, reversed, all zero, mixed in and out of range, placed exactly on the bound and one below it, and full-width random. At this length an 8-bit index can exceed the bound, so zero lanes and the moving limit are exercised at every width. Idle cycles with new data on the inputs check that the held result and the valid flag do not change.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    localparam int unsigned NUM_SIZES = 4;
    localparam int unsigned MAX_EBITS = 64;

    // Width in bits of an element of size code k
    function automatic int unsigned ebits_of(input int unsigned k);
        return 8 << k;
    endfunction

    // Number of elements of size code k in a vector of vlen bits
    function automatic int unsigned lanes_of(input int unsigned vlen, input int unsigned k);
        return vlen / ebits_of(k);
    endfunction

    // Index width needed to address n elements (at least 1)
    function automatic int unsigned selw_of(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vtbl_size_xbar.sv
module vtbl_size_xbar
    import vtbl_pkg::*;
#(
    parameter int unsigned VLEN  = 256,
    parameter int unsigned EBITS = 8
) (
    input  logic [VLEN-1:0] data_vec,
    input  logic [VLEN-1:0] index_vec,
    output logic [VLEN-1:0] gather_vec
);
    localparam int unsigned NELEM = VLEN / EBITS;
    localparam int unsigned SELW  = selw_of(NELEM);
    localparam logic [MAX_EBITS-1:0] BOUND = MAX_EBITS'(NELEM);

    logic [EBITS-1:0] elem [NELEM];

    for (genvar e = 0; e < NELEM; e++) begin : g_unpack
        assign elem[e] = data_vec[e*EBITS +: EBITS];
    end

    for (genvar i = 0; i < NELEM; i++) begin : g_lane
        logic [EBITS-1:0]     idx;
        logic [MAX_EBITS-1:0] idx_wide;
        logic [SELW-1:0]      sel;
        logic                 in_range;

        assign idx      = index_vec[i*EBITS +: EBITS];
        assign idx_wide = MAX_EBITS'(idx);
        assign in_range = idx_wide < BOUND;
        assign sel      = idx_wide[SELW-1:0];

        always_comb begin
            gather_vec[i*EBITS +: EBITS] = '0;
            if (in_range) begin
                gather_vec[i*EBITS +: EBITS] = elem[sel];
            end
        end
    end

endmodule

// File: rtl/vtbl_size_select.sv
module vtbl_size_select
    import vtbl_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  esz_e            size_code,
    input  logic [VLEN-1:0] cand [NUM_SIZES],
    output logic [VLEN-1:0] chosen
);
    always_comb begin
        unique case (size_code)
            ESZ_8:   chosen = cand[0];
            ESZ_16:  chosen = cand[1];
            ESZ_32:  chosen = cand[2];
            ESZ_64:  chosen = cand[3];
            default: chosen = '0;
        endcase
    end

endmodule

// File: rtl/vtbl_permute.sv
module vtbl_permute
    import vtbl_pkg::*;
#(
    parameter int unsigned VLEN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      in_size,
    input  logic [VLEN-1:0] in_data,
    input  logic [VLEN-1:0] in_index,
    output logic            out_valid,
    output logic [VLEN-1:0] out_vec
);
    logic [VLEN-1:0] per_size [NUM_SIZES];
    logic [VLEN-1:0] gathered;
    esz_e            size_code;
    logic            valid_q;
    logic [VLEN-1:0] vec_q;

    assign size_code = esz_e'(in_size);

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        vtbl_size_xbar #(
            .VLEN  (VLEN),
            .EBITS (ebits_of(k))
        ) u_xbar (
            .data_vec   (in_data),
            .index_vec  (in_index),
            .gather_vec (per_size[k])
        );
    end

    vtbl_size_select #(
        .VLEN (VLEN)
    ) u_select (
        .size_code (size_code),
        .cand      (per_size),
        .chosen    (gathered)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                vec_q <= gathered;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_vec   = vec_q;

endmodule

// File: rtl/vtbl_permute_chk.sv
module vtbl_permute_chk #(
    parameter int unsigned VLEN = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [1:0]      in_size,
    input logic [VLEN-1:0] in_data,
    input logic [VLEN-1:0] in_index,
    input logic            out_valid,
    input logic [VLEN-1:0] out_vec
);
    localparam int unsigned N64 = VLEN / 64;
    localparam int unsigned N8  = VLEN / 8;

    logic [N64-1:0] oor64;
    logic [N64-1:0] zero64;
    logic [N8-1:0]  oor8;

    for (genvar k = 0; k < N64; k++) begin : g_d
        assign oor64[k]  = in_index[k*64 +: 64] >= 64'(N64);
        assign zero64[k] = in_index[k*64 +: 64] == 64'd0;
    end
    for (genvar k = 0; k < N8; k++) begin : g_b
        assign oor8[k] = 16'(in_index[k*8 +: 8]) >= 16'(N8);
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R5
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec)); // R6
    AST_ZERO_WIDE_OOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd3 && &oor64) |=> out_vec == '0); // R4
    AST_ZERO_BYTE_OOR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd0 && &oor8) |=> out_vec == '0); // R4
    AST_WIDE_BROADCAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd3 && &zero64) |=> out_vec == {N64{$past(in_data[63:0])}}); // R3

endmodule

bind vtbl_permute vtbl_permute_chk #(.VLEN(VLEN)) u_chk (.*);

// File: tb/test_vtbl_permute.sv
module test_vtbl_permute;
    localparam int unsigned VB = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_size = 2'd0;
    logic [VB-1:0] in_data = '0;
    logic [VB-1:0] in_index = '0;
    logic          out_valid;
    logic [VB-1:0] out_vec;

    int     n_tests = 0;
    int     n_fail  = 0;
    string  cur_tag = "R7";

    // reference state
    logic          exp_valid = 1'b0;
    logic [VB-1:0] exp_vec   = '0;
    string         exp_tag   = "R7";
    bit            comparing = 1'b0;

    always #2 clk = ~clk;

    vtbl_permute #(.VLEN(VB)) i_vtbl_permute (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_size   (in_size),
        .in_data   (in_data),
        .in_index  (in_index),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    function automatic logic [VB-1:0] ref_gather(input logic [VB-1:0] d,
                                                 input logic [VB-1:0] ix,
                                                 input int unsigned sz);
        logic [VB-1:0] r;
        int unsigned   ew;
        int unsigned   n;
        r  = '0;
        ew = 8 << sz;
        n  = VB / ew;
        for (int i = 0; i < n; i++) begin
            logic [63:0] v;
            v = '0;
            for (int b = 0; b < ew; b++) v[b] = ix[i*ew + b];
            if (v < 64'(n)) begin
                for (int b = 0; b < ew; b++) r[i*ew + b] = d[int'(v)*ew + b];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid = 1'b0;
            exp_vec   = '0;
        end else begin
            exp_valid = in_valid;
            if (in_valid) begin
                exp_vec = ref_gather(in_data, in_index, in_size);
                exp_tag = cur_tag;
            end else begin
                exp_tag = "R6";
            end
        end
    end

    always @(negedge clk) begin
        if (comparing) begin
            n_tests++;
            if (out_valid !== exp_valid) begin
                n_fail++;
                $display("FAIL R5 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
            end
            n_tests++;
            if (out_vec !== exp_vec) begin
                n_fail++;
                $display("FAIL %s out_vec actual=%h expected=%h", exp_tag, out_vec, exp_vec);
            end
        end
    end

    function automatic logic [VB-1:0] rand_vec();
        logic [VB-1:0] v;
        for (int w = 0; w < VB/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    // mode: 0 ascending, 1 reversed, 2 zero, 3 mixed, 4 on bound, 5 full random
    task automatic issue(input int unsigned sz, input int unsigned mode);
        int unsigned   ew;
        int unsigned   n;
        logic [VB-1:0] ix;
        ew = 8 << sz;
        n  = VB / ew;
        ix = '0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] v;
            case (mode)
                0: v = 64'(i);
                1: v = 64'(n - 1 - i);
                2: v = 64'd0;
                3: v = 64'($urandom % (2 * n));
                4: v = (i % 2 == 0) ? 64'(n) : 64'(n - 1);
                default: v = {$urandom, $urandom};
            endcase
            for (int b = 0; b < ew; b++) ix[i*ew + b] = v[b];
        end
        case (mode)
            0: cur_tag = "R1";
            1: cur_tag = "R2";
            2: cur_tag = "R3";
            3: cur_tag = "R3";
            4: cur_tag = "R4";
            default: cur_tag = "R8";
        endcase
        in_valid = 1'b1;
        in_size  = 2'(sz);
        in_data  = rand_vec();
        in_index = ix;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_size  = 2'($urandom % 4);
        in_data  = rand_vec();
        in_index = rand_vec();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: cleared during reset
        n_tests++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            n_fail++;
            $display("FAIL R7 reset actual=%0b/%h expected=0/0", out_valid, out_vec);
        end
        rst = 1'b0;
        comparing = 1'b1;
        for (int sz = 0; sz < 4; sz++) begin
            for (int mode = 0; mode < 6; mode++) begin
                for (int rep = 0; rep < 3; rep++) begin
                    issue(sz, mode);
                    if (rep == 1) begin
                        idle();
                        idle();
                    end
                end
            end
        end
        for (int k = 0; k < 40; k++) begin
            issue($urandom % 4, $urandom % 6);
            if (k % 5 == 0) idle();
        end
        idle();
        idle();
        // R7: reset after activity clears state
        comparing = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            n_fail++;
            $display("FAIL R7 re-reset actual=%0b/%h expected=0/0", out_valid, out_vec);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule